// File: doc/BRIEF.md
# Parallel Bus Cycle Master with Ready Stretch

This block runs single read and write transfers on a legacy-style parallel peripheral bus. A local client presents an address, write data, a direction bit and a space bit (memory or I/O). While the block is idle, a valid request is accepted. The block then steps through a fixed four-clock bus cycle. It drives the address first, then pulls one of four active-low strobes low, then releases that strobe. Read data comes back on the client side with a one-clock completion pulse.

A slow target can hold the ready input low to stretch the cycle. Each clock in which ready is seen low at the end of a strobe clock adds one wait clock, up to a fixed cap. If ready is still low when the cap is reached, the block ends the cycle anyway and flags a timeout together with the completion pulse. Memory transfers drive the full wide address. I/O transfers use a narrower address space and drive zeros on the upper address lines.

Top module: `isa_cycle_master`

## Requirements
- R1: While reset is held, and after it, until a request is accepted: all four strobes are high, `bus_data_oe` is low, and `busy`, `done` and `timeout` are low.
- R2: A memory transfer drives all 20 bits of `req_addr` on `bus_addr`. An I/O transfer drives `req_addr[15:0]` on `bus_addr[15:0]` and zeros on `bus_addr[19:16]`. While idle, `bus_addr` is zero.
- R3: With ready high, a transfer lasts exactly four clocks after acceptance. Clock 1 has the address and no strobe. Clocks 2 and 3 have the strobe low. Clock 4 has the strobe released and `done` high.
- R4: The strobe used follows the request. A memory read uses `mem_rd_n`, a memory write `mem_wr_n`, an I/O read `io_rd_n` and an I/O write `io_wr_n`. No more than one strobe is ever low.
- R5: `bus_addr` stays constant from clock 1 through clock 4 of a transfer, so the address settles one full clock before the strobe falls.
- R6: Ready is sampled at the end of clock 3 and at the end of every wait clock. When it is low, one more wait clock follows with the strobe still low.
- R7: At most 6 wait clocks are inserted. If ready is still low at the end of the sixth, the cycle ends (cycle length 10), and `timeout` is high in the `done` clock only. Ready rising at the end of the sixth wait ends the cycle with no timeout.
- R8: Read data on `bus_data_in` is captured on the clock edge at which the strobe is released. It appears on `rd_data` in the `done` clock and holds until the next read completes.
- R9: `done` is high for exactly one clock per accepted request.
- R10: `busy` is high from the clock after acceptance through the `done` clock. Requests presented while `busy` is high are ignored: the running transfer keeps its address and no extra transfer starts.
- R11: For writes, `bus_data_oe` is high and `bus_data_out` carries the write data from clock 1 through clock 4. For reads, `bus_data_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Wait cap reached; valid with done |
| rd_data | output | 8 | Captured read data |
| bus_addr | output | 20 | Bus address lines |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| bus_data_out | output | 8 | Data driven onto the bus |
| bus_data_oe | output | 1 | Drive enable for bus_data_out |
| bus_data_in | input | 8 | Data read from the bus |
| tgt_ready | input | 1 | Target ready; low stretches the cycle |

## Verification
A request accepted at one edge gives bus clock 1 in the following clock. With no waits, the strobe is low in clocks 2 and 3, and `done`, `rd_data` and `timeout` are due in clock 4. Each wait pushes the `done` clock one later, to 4 + min(waits, 6). The bench drives inputs and samples outputs at falling edges. It numbers each clock of a transfer and compares every bus output against the value for that clock number. It sets ready for the edge that ends the current clock, so the wait count that a scenario requests maps exactly onto the clocks it checks.

// File: rtl/isa_bus_pkg.sv
// Package: shared state encoding for the bus cycle master.
// Assumes: one transfer in flight at a time.
package isa_bus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // no transfer
        ST_ADDR  = 3'd1,  // clock 1: address only
        ST_STB1  = 3'd2,  // clock 2: strobe low
        ST_STB2  = 3'd3,  // clock 3: strobe low, ready sampled at end
        ST_WAIT  = 3'd4,  // wait clock: strobe low, ready sampled at end
        ST_END   = 3'd5   // clock 4: strobe released, done
    } cyc_state_t;
endpackage

// File: rtl/isa_cycle_fsm.sv
// Module: sequences one bus cycle and counts inserted wait clocks.
// Assumes: start is only raised while the state is idle.
module isa_cycle_fsm
    import isa_bus_pkg::*;
#(
    parameter int MAX_WAIT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tgt_ready,
    output cyc_state_t state,
    output logic       capture,
    output logic       done,
    output logic       timeout
);
    localparam int WAIT_W = $clog2(MAX_WAIT + 1);

    cyc_state_t        nxt;
    logic [WAIT_W-1:0] wait_cnt;
    logic              tmo_q;

    // Next-state decision from ready and the wait count.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start ? ST_ADDR : ST_IDLE;
            ST_ADDR: nxt = ST_STB1;
            ST_STB1: nxt = ST_STB2;
            ST_STB2: nxt = tgt_ready ? ST_END : ST_WAIT;
            ST_WAIT: nxt = (tgt_ready || wait_cnt == WAIT_W'(MAX_WAIT)) ? ST_END : ST_WAIT;
            ST_END:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Wait counter: holds the number of wait clocks entered so far.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wait_cnt <= '0;
        else if (state == ST_STB2 && nxt == ST_WAIT) wait_cnt <= WAIT_W'(1);
        else if (state == ST_WAIT && nxt == ST_WAIT) wait_cnt <= wait_cnt + WAIT_W'(1);
        else if (state == ST_IDLE)           wait_cnt <= '0;
    end

    // Timeout flag: set when the cap ends a cycle with ready still low.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tmo_q <= 1'b0;
        else if (nxt == ST_END)     tmo_q <= (state == ST_WAIT) && !tgt_ready;
        else                        tmo_q <= 1'b0;
    end

    assign capture = (state == ST_STB2 || state == ST_WAIT) && nxt == ST_END;
    assign done    = (state == ST_END);
    assign timeout = done && tmo_q;

    assert_wait_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WAIT_W'(MAX_WAIT));
    assert_timeout_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STB2 && tgt_ready) |=> done);
endmodule

// File: rtl/isa_bus_drive.sv
// Module: decodes the cycle state into address, strobes and write data.
// Assumes: the request fields are held constant for the whole transfer.
module isa_bus_drive
    import isa_bus_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int IO_ADDR_W = 16,
    parameter int DATA_W    = 8
) (
    input  cyc_state_t        state,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe
);
    logic [ADDR_W-1:0] io_addr;
    logic              active;
    logic              stb_on;

    // Narrow I/O address, padded with zeros when the bus is wider.
    generate
        if (ADDR_W > IO_ADDR_W) begin : g_io_pad
            assign io_addr = {{(ADDR_W - IO_ADDR_W){1'b0}}, req_addr[IO_ADDR_W-1:0]};
        end else begin : g_io_full
            assign io_addr = req_addr;
        end
    endgenerate

    assign active = (state != ST_IDLE);
    assign stb_on = (state == ST_STB1) || (state == ST_STB2) || (state == ST_WAIT);

    // Address, strobe and write-data decode.
    always_comb begin
        bus_addr     = active ? (req_io ? io_addr : req_addr) : '0;
        mem_rd_n     = !(stb_on && !req_io && !req_write);
        mem_wr_n     = !(stb_on && !req_io &&  req_write);
        io_rd_n      = !(stb_on &&  req_io && !req_write);
        io_wr_n      = !(stb_on &&  req_io &&  req_write);
        bus_data_oe  = active && req_write;
        bus_data_out = bus_data_oe ? req_wdata : '0;
    end

    assert_one_strobe_R4: assert property (@(state)
        $onehot0({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}));
endmodule

// File: rtl/isa_read_capture.sv
// Module: latches bus read data at the edge that releases the strobe.
// Assumes: capture is high only in the last strobe clock.
module isa_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              is_read,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] rd_data
);
    // Read data register, updated only by completing reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_data <= '0;
        else if (capture && is_read) rd_data <= bus_data_in;
    end

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_data));
endmodule

// File: rtl/isa_cycle_master.sv
// Module: top of the parallel bus cycle master; latches a request while idle
// and runs one bus transfer with ready-driven wait clocks.
// Assumes: the client holds req_valid until it sees busy.
module isa_cycle_master
    import isa_bus_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int IO_ADDR_W = 16,
    parameter int DATA_W    = 8,
    parameter int MAX_WAIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              tgt_ready
);
    cyc_state_t        state;
    logic              start;
    logic              capture;
    logic              wr_q;
    logic              io_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign start = req_valid && (state == ST_IDLE);
    assign busy  = (state != ST_IDLE);

    // Request latch: loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            io_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            wr_q    <= req_write;
            io_q    <= req_io;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    isa_cycle_fsm #(.MAX_WAIT(MAX_WAIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tgt_ready (tgt_ready),
        .state     (state),
        .capture   (capture),
        .done      (done),
        .timeout   (timeout)
    );

    isa_bus_drive #(.ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state        (state),
        .req_write    (wr_q),
        .req_io       (io_q),
        .req_addr     (addr_q),
        .req_wdata    (wdata_q),
        .bus_addr     (bus_addr),
        .mem_rd_n     (mem_rd_n),
        .mem_wr_n     (mem_wr_n),
        .io_rd_n      (io_rd_n),
        .io_wr_n      (io_wr_n),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe)
    );

    isa_read_capture #(.DATA_W(DATA_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .is_read     (!wr_q),
        .bus_data_in (bus_data_in),
        .rd_data     (rd_data)
    );

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(bus_addr));
    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));
    assert_read_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !mem_rd_n == 1'b0 && !io_rd_n == 1'b0);
    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: tb/isa_cycle_master_tb.sv
// Bench: directed scenarios, one task each; samples at falling edges.
module isa_cycle_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, timeout;
    logic [7:0]  rd_data;
    logic [19:0] bus_addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic [7:0]  bus_data_out;
    logic        bus_data_oe;
    logic [7:0]  bus_data_in = '0;
    logic        tgt_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    isa_cycle_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .timeout(timeout), .rd_data(rd_data),
        .bus_addr(bus_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in), .tgt_ready(tgt_ready)
    );

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    function automatic string busstr();
        return $sformatf("addr=%h stb=%b%b%b%b oe=%b dout=%h busy=%b done=%b tmo=%b",
            bus_addr, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, bus_data_oe,
            bus_data_out, busy, done, timeout);
    endfunction

    // R1: idle/reset outputs.
    task automatic check_idle(input string req);
        chk(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && !bus_data_oe && !busy
            && !done && !timeout && bus_addr == 20'h0, req, busstr(), "all idle");
    endtask

    // Runs one transfer; checks every clock of it. hold: keep requesting while busy.
    task automatic run_xfer(input bit wr, input bit io, input logic [19:0] addr,
                            input logic [7:0] wd, input logic [7:0] rv,
                            input int nwait, input bit hold, input string tag);
        int w = (nwait > 6) ? 6 : nwait;
        int total = 4 + w;
        logic [19:0] eaddr = io ? {4'h0, addr[15:0]} : addr;
        logic [7:0]  prev_rd = rd_data;
        req_valid = 1'b1; req_write = wr; req_io = io; req_addr = addr; req_wdata = wd;
        bus_data_in = rv;
        tgt_ready = 1'b0;
        @(negedge clk);
        for (int c = 1; c <= total; c++) begin
            bit slow = (c >= 2) && (c <= 3 + w);
            bit edone = (c == total);
            logic [3:0] estb = 4'b1111;
            logic [3:0] astb = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
            if (slow) estb[3 - {io, wr}] = 1'b0;
            chk(bus_addr == eaddr && busy, "R2/R5/R10",
                busstr(), $sformatf("clk%0d addr=%h busy=1 (%s)", c, eaddr, tag));
            chk(astb == estb, "R3/R4/R6", $sformatf("stb=%b", astb),
                $sformatf("clk%0d stb=%b (%s)", c, estb, tag));
            chk(bus_data_oe == wr && (!wr || bus_data_out == wd), "R11",
                busstr(), $sformatf("oe=%b dout=%h (%s)", wr, wd, tag));
            chk(done == edone && timeout == (edone && nwait > 6), "R7/R9",
                busstr(), $sformatf("clk%0d done=%b tmo=%b (%s)", c, edone,
                edone && nwait > 6, tag));
            if (edone)
                chk(rd_data == (wr ? prev_rd : rv), "R8", $sformatf("%h", rd_data),
                    $sformatf("%h (%s)", wr ? prev_rd : rv, tag));
            tgt_ready = (c >= 3 + nwait);
            if (hold) begin
                req_addr = 20'hABCDE; req_io = ~io;
                req_valid = (c < total);
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        tgt_ready = 1'b1;
        bus_data_in = ~rv;
        check_idle({"R9/R10 after ", tag});
        @(negedge clk);
        check_idle({"R10 no extra transfer ", tag});
        chk(rd_data == (wr ? prev_rd : rv), "R8 hold", $sformatf("%h", rd_data),
            $sformatf("%h", wr ? prev_rd : rv));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        run_xfer(1'b0, 1'b0, 20'hF1234, 8'h00, 8'h5A, 0, 1'b0, "R3 mem read");
        run_xfer(1'b1, 1'b0, 20'h8ABCD, 8'hC3, 8'h11, 0, 1'b0, "R4 mem write");
        run_xfer(1'b0, 1'b1, 20'h9BEEF, 8'h00, 8'hA5, 2, 1'b0, "R6 io read 2 waits");
        run_xfer(1'b1, 1'b1, 20'h71357, 8'h3C, 8'h22, 1, 1'b0, "R2 io write");
        run_xfer(1'b0, 1'b0, 20'h00042, 8'h00, 8'h96, 6, 1'b0, "R7 six waits ready");
        run_xfer(1'b0, 1'b1, 20'h40008, 8'h00, 8'h69, 9, 1'b0, "R7 timeout");
        run_xfer(1'b1, 1'b0, 20'h12345, 8'hE7, 8'h33, 1, 1'b1, "R10 hold-off");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule